// File: doc/BRIEF.md
# Multimode Self-Test Register

This block is a register of configurable width that sits between two pieces of combinational logic. It can serve four purposes. As an ordinary pipeline stage it captures a parallel word on every clock. As a scan register it forms a serial chain from a scan input to a scan output. In self-test operation it becomes a linear feedback shift register. With constant parallel inputs, that register produces pseudorandom patterns for the logic it drives. When the inputs carry the responses of the logic feeding it, it folds those responses into a multiple-input signature.

A two-bit mode input selects the behaviour on each clock. Two of these registers placed around a pair of logic blocks can exchange roles: one generates patterns while the other compacts responses, and then the two swap. Deciding which register takes which role is left to a controller outside this block. After a run the signature is available on the parallel output at once, or it can be shifted out serially in scan mode, most significant stage first.

Top module: `mmst_reg`

## Requirements
- R1: An active-low asynchronous reset (rst_n low) clears every stage to zero at once, without waiting for a clock.
- R2: With mode = 2'b00, the register is all zeros after the next rising clock edge.
- R3: With mode = 2'b01, the register holds the value that par_in had at the next rising clock edge.
- R4: With mode = 2'b10, each rising edge shifts the register toward the higher index. Stage 0 takes scan_in and stage i takes the old stage i-1.
- R5: With mode = 2'b11, each rising edge sets stage 0 to fb XOR par_in[0] and stage i to old stage i-1 XOR par_in[i]. fb is the XOR of the old stages whose bit is set in the TAP_MASK parameter. The default for WIDTH=8 is 8'hB8, and a 4-bit instance with mask 4'hC realises the feedback 1 + x^3 + x^4.
- R6: In mode 2'b11 with par_in held at zero, a nonzero state never becomes zero. With the default masks, the sequence started from state 1 returns to 1 after exactly 2^WIDTH - 1 clocks: 255 for 8 bits and 15 for 4 bits.
- R7: par_out always equals the register contents, and scan_out always equals the highest stage, par_out[WIDTH-1].
- R8: A signature left in the register after a test run comes out on scan_out most significant bit first over WIDTH clocks of mode 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 clear, 01 load, 10 scan shift, 11 pattern/signature |
| par_in | input | WIDTH | Parallel data or responses from upstream logic |
| scan_in | input | 1 | Serial input to stage 0 in scan mode |
| par_out | output | WIDTH | Register contents, patterns or signature |
| scan_out | output | 1 | Highest stage, end of the serial chain |

## Verification
Every mode acts on the single register stage, so the effect of a mode and input word is due on par_out and scan_out exactly one rising edge after it is applied. The bench drives inputs on the falling edge and compares both outputs against its own reference model on the following falling edge. The asynchronous reset is the only result that is due without an edge, and it is checked one time step after rst_n falls. In the period and serial-readout checks, one falling-edge sample is taken per clock, so the cycle count stays exact.

// File: rtl/mmst_pkg.sv
package mmst_pkg;

    typedef enum logic [1:0] {
        MODE_CLEAR = 2'b00,
        MODE_LOAD  = 2'b01,
        MODE_SCAN  = 2'b10,
        MODE_TEST  = 2'b11
    } mmst_mode_e;

endpackage

// File: rtl/mmst_feedback.sv
module mmst_feedback #(
    parameter int               WIDTH    = 8,
    parameter logic [WIDTH-1:0] TAP_MASK = 8'hB8
) (
    input  logic [WIDTH-1:0] stage,
    output logic             fb
);
    logic [WIDTH-1:0] tapped;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_tap
            if (TAP_MASK[gi]) begin : g_on
                assign tapped[gi] = stage[gi];
            end else begin : g_off
                assign tapped[gi] = 1'b0;
            end
        end
    endgenerate

    assign fb = ^tapped;
endmodule

// File: rtl/mmst_next.sv
module mmst_next
    import mmst_pkg::*;
#(
    parameter int               WIDTH    = 8,
    parameter logic [WIDTH-1:0] TAP_MASK = 8'hB8
) (
    input  mmst_mode_e       mode,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] par_in,
    input  logic             scan_in,
    output logic [WIDTH-1:0] nxt
);
    logic             fb;
    logic [WIDTH-1:0] shifted;
    logic [WIDTH-1:0] lfsr_d;

    mmst_feedback #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) u_fb (
        .stage (cur),
        .fb    (fb)
    );

    assign shifted = {cur[WIDTH-2:0], scan_in};

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_stage
            if (gi == 0) begin : g_head
                assign lfsr_d[gi] = fb ^ par_in[gi];
            end else begin : g_body
                assign lfsr_d[gi] = cur[gi-1] ^ par_in[gi];
            end
        end
    endgenerate

    always_comb begin
        unique case (mode)
            MODE_CLEAR: nxt = '0;
            MODE_LOAD:  nxt = par_in;
            MODE_SCAN:  nxt = shifted;
            default:    nxt = lfsr_d;
        endcase
    end
endmodule

// File: rtl/mmst_reg.sv
module mmst_reg
    import mmst_pkg::*;
#(
    parameter int               WIDTH    = 8,
    parameter logic [WIDTH-1:0] TAP_MASK = 8'hB8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] par_in,
    input  logic             scan_in,
    output logic [WIDTH-1:0] par_out,
    output logic             scan_out
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] stage;
    } reg_state_t;

    reg_state_t state_d, state_q;
    mmst_mode_e mode_e;
    logic [WIDTH-1:0] next_stage;

    assign mode_e = mmst_mode_e'(mode);

    mmst_next #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) u_next (
        .mode    (mode_e),
        .cur     (state_q.stage),
        .par_in  (par_in),
        .scan_in (scan_in),
        .nxt     (next_stage)
    );

    always_comb begin
        state_d       = state_q;
        state_d.stage = next_stage;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign par_out  = state_q.stage;
    assign scan_out = state_q.stage[MSB];

    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (par_out == '0));

    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |=> (par_out == $past(par_in)));

    a_r4_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> (par_out == {$past(par_out[WIDTH-2:0]), $past(scan_in)}));

    a_r6_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && par_in == '0 && par_out != '0) |=> (par_out != '0));

    a_r8_chain_end: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> (scan_out == $past(par_out[WIDTH-2])));

    initial begin
        assert (WIDTH >= 2);
    end
endmodule

// File: tb/tb_mmst_reg.sv
module tb_mmst_reg;
    localparam int W  = 8;
    localparam int W4 = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [W-1:0]  par_in = '0;
    logic          scan_in = 1'b0;
    logic [W-1:0]  par_out;
    logic          scan_out;

    logic [1:0]    mode4 = 2'b00;
    logic [W4-1:0] par_in4 = '0;
    logic [W4-1:0] par_out4;
    logic          scan_out4;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] exp_q = '0;

    always #4 clk = ~clk;

    mmst_reg #(.WIDTH(W), .TAP_MASK(8'hB8)) dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .par_in(par_in),
        .scan_in(scan_in), .par_out(par_out), .scan_out(scan_out)
    );

    mmst_reg #(.WIDTH(W4), .TAP_MASK(4'hC)) dut4 (
        .clk(clk), .rst_n(rst_n), .mode(mode4), .par_in(par_in4),
        .scan_in(1'b0), .par_out(par_out4), .scan_out(scan_out4)
    );

    function automatic logic [W-1:0] model(logic [W-1:0] s, logic [1:0] m,
                                           logic [W-1:0] d, logic si);
        logic f;
        f = s[7] ^ s[5] ^ s[4] ^ s[3];
        case (m)
            2'b00:   return '0;
            2'b01:   return d;
            2'b10:   return {s[W-2:0], si};
            default: return {s[W-2:0], f} ^ d;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic step(input logic [1:0] m, input logic [W-1:0] d, input logic si,
                        input string req);
        mode = m; par_in = d; scan_in = si;
        exp_q = model(exp_q, m, d, si);
        @(posedge clk);
        @(negedge clk);
        check(par_out == exp_q, req, par_out, exp_q);
        check(scan_out == exp_q[W-1], "R7", {7'd0, scan_out}, {7'd0, exp_q[W-1]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int unused;
        logic [W-1:0] sig;
        logic [W-1:0] got;
        int n;
        unused = $urandom(32'd4242);

        // R1 reset state
        #3;
        check(par_out == '0, "R1", par_out, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // directed: R3 load, R2 clear, R4 shift, R5 compaction
        step(2'b01, 8'hA5, 1'b0, "R3");
        step(2'b01, 8'h3C, 1'b0, "R3");
        step(2'b00, 8'hFF, 1'b1, "R2");
        step(2'b10, 8'hFF, 1'b1, "R4");
        step(2'b10, 8'h00, 1'b0, "R4");
        step(2'b10, 8'h00, 1'b1, "R4");
        step(2'b01, 8'h80, 1'b0, "R3");
        step(2'b11, 8'h00, 1'b0, "R5");
        step(2'b11, 8'h5A, 1'b0, "R5");
        step(2'b11, 8'hFF, 1'b1, "R5");

        // random mix across all modes
        for (int i = 0; i < 400; i++) begin
            logic [1:0] m;
            m = 2'($urandom_range(0, 3));
            step(m, 8'($urandom), 1'($urandom), m == 2'b00 ? "R2" :
                 m == 2'b01 ? "R3" : m == 2'b10 ? "R4" : "R5");
        end

        // R5 + R8: signature run then serial readout
        step(2'b00, 8'h00, 1'b0, "R2");
        for (int i = 0; i < 30; i++) step(2'b11, 8'($urandom), 1'b0, "R5");
        sig = exp_q;
        check(par_out == sig, "R8", par_out, sig);
        got = '0;
        for (int i = 0; i < W; i++) begin
            got = {got[W-2:0], scan_out};
            step(2'b10, 8'h00, 1'b0, "R4");
        end
        check(got == sig, "R8", got, sig);

        // R6 generator period, both widths
        step(2'b01, 8'h01, 1'b0, "R3");
        mode4 = 2'b01; par_in4 = 4'h1;
        @(posedge clk); @(negedge clk);
        mode = 2'b11; par_in = '0; mode4 = 2'b11; par_in4 = '0;
        n = 0;
        do begin
            @(posedge clk); @(negedge clk);
            n++;
            if (par_out == '0) check(1'b0, "R6", par_out, 8'h01);
        end while (par_out != 8'h01 && n < 300);
        check(n == 255, "R6", 8'(n), 8'd255);
        mode = 2'b01; par_in = 8'h01;
        step(2'b01, 8'h01, 1'b0, "R3");
        mode4 = 2'b01; par_in4 = 4'h1;
        @(posedge clk); @(negedge clk);
        mode4 = 2'b11; par_in4 = '0;
        n = 0;
        do begin
            @(posedge clk); @(negedge clk);
            n++;
        end while (par_out4 != 4'h1 && n < 40);
        check(n == 15, "R6", 8'(n), 8'd15);
        check(scan_out4 == par_out4[W4-1], "R7", {7'd0, scan_out4}, {7'd0, par_out4[W4-1]});

        // R1 asynchronous reset mid-run
        step(2'b01, 8'hC3, 1'b0, "R3");
        #1 rst_n = 1'b0;
        #1;
        check(par_out == '0, "R1", par_out, '0);
        exp_q = '0;
        @(negedge clk);
        rst_n = 1'b1;
        step(2'b01, 8'h77, 1'b0, "R3");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule